// File: doc/BRIEF.md
# Split-Field Pixel Clock Divider

This block derives a panel pixel clock from the display controller's reference clock. A 32-bit timing word holds the divide setting in two bit fields that are not next to each other, plus a bypass flag. The block decodes the word, counts reference cycles to build each output period, and drives a divided clock together with a single-cycle pixel enable. Logic on the reference clock uses the enable, and the panel uses the clock.

When bypass is clear, the divide ratio is the two fields joined together plus two. Setting the bypass flag is the only way to divide by one: the reference clock then passes straight through, and the pixel enable stays high. A new setting never cuts a period short. It is held back until the output period in progress has finished, so the output shows no short pulse. The ratio actually in force can be read back at any time.

Top module: `pclk_div`

## Requirements
- R1: While reset is asserted, pix_en is 0, pix_clk is 0 and eff_div reads 2.
- R2: When timing_word bit 26 (bypass) is 1, eff_div reads 1, pix_en is 1 every reference cycle, pix_clk follows ref_clk, and the divisor fields have no effect on any output.
- R3: When bypass is 0, each output period lasts N reference cycles, with N equal to the assembled field value plus 2, and eff_div reads N. The smallest ratio is 2, given by all field bits 0.
- R4: The assembled field value is {timing_word[31:27], timing_word[4:0]}: bits 4:0 form the low five bits and bits 31:27 sit directly above them. Bits 25:5 have no effect.
- R5: In divided mode, pix_en is high for exactly one reference cycle per period. That cycle is the first cycle of the high phase of pix_clk.
- R6: In divided mode, pix_clk is high for (N+1)/2 reference cycles (rounded down) and then low for the rest of the period. Even ratios therefore give a 50% duty cycle, and odd ratios give a high phase one cycle longer than the low phase.
- R7: A change to timing_word takes effect only at the start of the next output period. eff_div and the period in progress keep the old setting until then.
- R8: The largest ratio is 1025, given by all ten field bits set to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| timing_word | input | 32 | Timing word: divisor low field [4:0], high field [31:27], bypass flag [26] |
| pix_clk | output | 1 | Divided pixel clock, or ref_clk in bypass |
| pix_en | output | 1 | One reference cycle per pixel period |
| eff_div | output | 11 | Divide ratio in force (1 in bypass) |

## Verification
The hardest case to produce from the ports is a setting that changes partway through a period. The change must be timed against the internal period position, which the ports do not show. The bench locks onto pix_en to find the start of a period, steps a known number of reference cycles into it, and then rewrites timing_word. It then checks that the old period still runs its full length and that eff_div changes only at the next pix_en. Bypass entry and exit are handled the same way: the bench changes the fields while bypass is set and checks that pix_en and eff_div stay unchanged.

// File: rtl/pclk_div_pkg.sv
package pclk_div_pkg;

  // Implicit offset added to the assembled divisor fields.
  localparam int unsigned PCLK_OFFSET = 2;

  // Width needed to hold the largest ratio: 2**field_bits - 1 + offset.
  function automatic int pclk_ratio_width(int lo_w, int hi_w);
    return $clog2((1 << (lo_w + hi_w)) + PCLK_OFFSET);
  endfunction

  // Divide ratio from the assembled field value.
  function automatic int unsigned pclk_ratio(int unsigned field);
    return field + PCLK_OFFSET;
  endfunction

  // Cycles of the high phase; odd ratios give the extra cycle to high.
  function automatic int unsigned pclk_high_len(int unsigned ratio);
    return (ratio + 1) / 2;
  endfunction

endpackage

// File: rtl/pclk_cfg_decode.sv
module pclk_cfg_decode
  import pclk_div_pkg::*;
#(
  parameter int REG_W   = 32,
  parameter int LO_LSB  = 0,
  parameter int LO_W    = 5,
  parameter int HI_LSB  = 27,
  parameter int HI_W    = 5,
  parameter int BYP_BIT = 26,
  parameter int RATIO_W = 11
) (
  input  logic [REG_W-1:0]   cfg_word,
  output logic               dec_byp,
  output logic [RATIO_W-1:0] dec_ratio
);

  localparam int FIELD_W = LO_W + HI_W;

  logic [FIELD_W-1:0] field;
  logic               unused_cfg_bits;

  generate
    if (HI_W > 0) begin : g_split
      // High field sits directly above the low field.
      assign field = {cfg_word[HI_LSB +: HI_W], cfg_word[LO_LSB +: LO_W]};
    end else begin : g_low_only
      assign field = cfg_word[LO_LSB +: LO_W];
    end
  endgenerate

  assign dec_byp   = cfg_word[BYP_BIT];
  assign dec_ratio = RATIO_W'(pclk_ratio(32'(field)));

  // Bits outside the fields carry no meaning here.
  assign unused_cfg_bits = ^cfg_word;

endmodule

// File: rtl/pclk_cfg_shadow.sv
module pclk_cfg_shadow
  import pclk_div_pkg::*;
#(
  parameter int RATIO_W = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               period_end,
  input  logic               dec_byp,
  input  logic [RATIO_W-1:0] dec_ratio,
  output logic               nxt_byp,
  output logic [RATIO_W-1:0] nxt_ratio,
  output logic               act_byp,
  output logic [RATIO_W-1:0] act_ratio
);

  // A new setting is only taken at a period boundary.
  always_comb begin
    if (period_end) begin
      nxt_byp   = dec_byp;
      nxt_ratio = dec_ratio;
    end else begin
      nxt_byp   = act_byp;
      nxt_ratio = act_ratio;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_byp   <= 1'b0;
      act_ratio <= RATIO_W'(PCLK_OFFSET);
    end else begin
      act_byp   <= nxt_byp;
      act_ratio <= nxt_ratio;
    end
  end

  // R7: setting in force cannot move inside a period.
  assert_hold_mid_period_R7: assert property (@(posedge clk) disable iff (rst)
    !period_end |=> ($stable(act_ratio) && $stable(act_byp)));

endmodule

// File: rtl/pclk_phase_gen.sv
module pclk_phase_gen
  import pclk_div_pkg::*;
#(
  parameter int RATIO_W = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               act_byp,
  input  logic [RATIO_W-1:0] act_ratio,
  input  logic               nxt_byp,
  input  logic [RATIO_W-1:0] nxt_ratio,
  output logic               period_end,
  output logic               div_q,
  output logic               pix_en
);

  logic [RATIO_W-1:0] pos;
  logic [RATIO_W-1:0] pos_nxt;
  logic               high_nxt;

  // Last cycle of a period; every cycle is one in bypass.
  assign period_end = act_byp | (pos == act_ratio - 1'b1);

  always_comb begin
    pos_nxt  = period_end ? '0 : pos + 1'b1;
    high_nxt = pos_nxt < RATIO_W'(pclk_high_len(32'(nxt_ratio)));
  end

  // Outputs are registered so the clock pin never sees comparator glitches.
  // Reset parks the counter on the last cycle of a ratio-2 period, low phase.
  always_ff @(posedge clk) begin
    if (rst) begin
      pos    <= RATIO_W'(PCLK_OFFSET - 1);
      div_q  <= 1'b0;
      pix_en <= 1'b0;
    end else begin
      pos    <= pos_nxt;
      div_q  <= nxt_byp | high_nxt;
      pix_en <= nxt_byp | (pos_nxt == '0);
    end
  end

  // R5: enable marks the first high cycle.
  assert_en_in_high_R5: assert property (@(posedge clk) disable iff (rst)
    (pix_en && !act_byp) |-> div_q);

  // R5: never two enables back to back while dividing.
  assert_en_single_R5: assert property (@(posedge clk) disable iff (rst)
    (pix_en && !act_byp) |=> !pix_en);

  // R6: each divided period closes in the low phase.
  assert_end_low_R6: assert property (@(posedge clk) disable iff (rst)
    (period_end && !act_byp) |-> !div_q);

endmodule

// File: rtl/pclk_div.sv
module pclk_div
  import pclk_div_pkg::*;
#(
  parameter int REG_W   = 32,
  parameter int LO_LSB  = 0,
  parameter int LO_W    = 5,
  parameter int HI_LSB  = 27,
  parameter int HI_W    = 5,
  parameter int BYP_BIT = 26,
  localparam int RATIO_W = pclk_ratio_width(LO_W, HI_W)
) (
  input  logic               ref_clk,
  input  logic               rst,
  input  logic [REG_W-1:0]   timing_word,
  output logic               pix_clk,
  output logic               pix_en,
  output logic [RATIO_W-1:0] eff_div
);

  logic               dec_byp;
  logic [RATIO_W-1:0] dec_ratio;
  logic               nxt_byp;
  logic [RATIO_W-1:0] nxt_ratio;
  logic               act_byp;
  logic [RATIO_W-1:0] act_ratio;
  logic               period_end;
  logic               div_q;

  pclk_cfg_decode #(
    .REG_W   (REG_W),
    .LO_LSB  (LO_LSB),
    .LO_W    (LO_W),
    .HI_LSB  (HI_LSB),
    .HI_W    (HI_W),
    .BYP_BIT (BYP_BIT),
    .RATIO_W (RATIO_W)
  ) u_decode (
    .cfg_word  (timing_word),
    .dec_byp   (dec_byp),
    .dec_ratio (dec_ratio)
  );

  pclk_cfg_shadow #(
    .RATIO_W (RATIO_W)
  ) u_shadow (
    .clk        (ref_clk),
    .rst        (rst),
    .period_end (period_end),
    .dec_byp    (dec_byp),
    .dec_ratio  (dec_ratio),
    .nxt_byp    (nxt_byp),
    .nxt_ratio  (nxt_ratio),
    .act_byp    (act_byp),
    .act_ratio  (act_ratio)
  );

  pclk_phase_gen #(
    .RATIO_W (RATIO_W)
  ) u_phase (
    .clk        (ref_clk),
    .rst        (rst),
    .act_byp    (act_byp),
    .act_ratio  (act_ratio),
    .nxt_byp    (nxt_byp),
    .nxt_ratio  (nxt_ratio),
    .period_end (period_end),
    .div_q      (div_q),
    .pix_en     (pix_en)
  );

  // Switches happen just after a rising edge, where both sources are high.
  assign pix_clk = act_byp ? ref_clk : div_q;
  assign eff_div = act_byp ? RATIO_W'(1) : act_ratio;

  // R2: bypass holds the enable high on every cycle.
  assert_bypass_en_R2: assert property (@(posedge ref_clk) disable iff (rst)
    act_byp |-> pix_en);

endmodule

// File: tb/tb_pclk_div.sv
`timescale 1ns/1ps
module tb_pclk_div;

  logic        ref_clk = 1'b0;
  logic        rst;
  logic [31:0] timing_word;
  logic        pix_clk;
  logic        pix_en;
  logic [10:0] eff_div;

  int total = 0;
  int fails = 0;

  always #2 ref_clk = ~ref_clk;

  pclk_div dut (
    .ref_clk     (ref_clk),
    .rst         (rst),
    .timing_word (timing_word),
    .pix_clk     (pix_clk),
    .pix_en      (pix_en),
    .eff_div     (eff_div)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_ratio(input logic [31:0] w);
    logic [9:0] f;
    f = {w[31:27], w[4:0]};
    return int'(f) + 2;
  endfunction

  // Advance at negedges until pix_en is seen high.
  task automatic sync_en();
    while (!pix_en) @(negedge ref_clk);
  endtask

  // From an enable cycle, count cycles and high samples until the next one.
  task automatic measure(output int per, output int hi);
    sync_en();
    per = 0;
    hi  = 0;
    do begin
      per++;
      if (pix_clk) hi++;
      @(negedge ref_clk);
    end while (!pix_en);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    timing_word = 32'h0000_0003;
    repeat (3) @(negedge ref_clk);
    check(pix_en == 1'b0, "R1", "pix_en in reset", pix_en, 0);
    check(pix_clk == 1'b0, "R1", "pix_clk in reset", pix_clk, 0);
    check(eff_div == 11'd2, "R1", "eff_div in reset", eff_div, 2);
    rst = 1'b0;
  endtask

  task automatic t_ratio(input logic [31:0] w, input string req);
    int per, hi, n;
    n = exp_ratio(w);
    @(negedge ref_clk);
    timing_word = w;
    measure(per, hi);
    measure(per, hi);
    check(int'(eff_div) == n, req, "eff_div", eff_div, n);
    check(per == n, req, "period length", per, n);
    check(hi == (n + 1) / 2, "R6", "high phase", hi, (n + 1) / 2);
  endtask

  task automatic t_enable_width();
    int cnt;
    @(negedge ref_clk);
    timing_word = 32'h0000_0006;   // ratio 8
    sync_en();
    @(negedge ref_clk);
    sync_en();
    cnt = 0;
    for (int i = 0; i < 16; i++) begin
      if (pix_en) cnt++;
      @(negedge ref_clk);
    end
    check(cnt == 2, "R5", "enables in two periods", cnt, 2);
  endtask

  task automatic t_bypass();
    int bad_en, bad_lo, bad_hi, per, hi;
    @(negedge ref_clk);
    timing_word = 32'h0400_0005;
    repeat (40) @(negedge ref_clk);
    check(eff_div == 11'd1, "R2", "eff_div in bypass", eff_div, 1);
    bad_en = 0; bad_lo = 0; bad_hi = 0;
    for (int i = 0; i < 10; i++) begin
      if (!pix_en) bad_en++;
      if (pix_clk) bad_lo++;
      @(posedge ref_clk);
      #1;
      if (!pix_clk) bad_hi++;
      @(negedge ref_clk);
    end
    check(bad_en == 0, "R2", "cycles without pix_en", bad_en, 0);
    check(bad_lo == 0 && bad_hi == 0, "R2", "pix_clk not following ref_clk",
          bad_lo + bad_hi, 0);
    timing_word = 32'hFC00_001F;   // fields changed, bypass kept
    bad_en = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge ref_clk);
      if (!pix_en || eff_div != 11'd1) bad_en++;
    end
    check(bad_en == 0, "R2", "field change in bypass", bad_en, 0);
    timing_word = 32'h0000_0004;   // ratio 6
    measure(per, hi);
    measure(per, hi);
    check(per == 6, "R2", "period after leaving bypass", per, 6);
  endtask

  task automatic t_switch();
    int per, hi;
    @(negedge ref_clk);
    timing_word = 32'h0000_0004;   // ratio 6
    measure(per, hi);
    measure(per, hi);              // now at an enable cycle
    per = 1;
    repeat (2) begin
      @(negedge ref_clk);
      per++;
    end
    timing_word = 32'h0000_0001;   // ratio 3
    @(negedge ref_clk);
    per++;
    check(eff_div == 11'd6, "R7", "eff_div mid period", eff_div, 6);
    while (!pix_en) begin
      @(negedge ref_clk);
      if (!pix_en) per++;
    end
    check(per == 6, "R7", "old period length kept", per, 6);
    check(eff_div == 11'd3, "R7", "eff_div at new period", eff_div, 3);
    measure(per, hi);
    check(per == 3, "R7", "new period length", per, 3);
  endtask

  initial begin
    repeat (200000) @(posedge ref_clk);
    check(1'b0, "WATCHDOG", "timeout", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    t_reset();
    t_ratio(32'h0000_0000, "R3");   // ratio 2
    t_ratio(32'h0000_0003, "R3");   // ratio 5, odd
    t_ratio(32'h0800_0000, "R4");   // high field 1 -> 34
    t_ratio(32'h13FF_FFE7, "R4");   // lo 7, hi 2, junk in 25:5 -> 73
    t_ratio(32'hF800_001F, "R8");   // ratio 1025
    t_enable_width();
    t_bypass();
    t_switch();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule